// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. On every clock it takes an accumulator operand, a second operand, a 4-bit operation code and the present zero, subtract, half-carry and carry flags. One cycle later it presents the result byte, a strobe that says whether that byte should be written back to the accumulator, the four outgoing flags and a mask that marks which of them the operation defined.

The operations are add and add-with-carry, subtract and subtract-with-borrow, compare, AND, XOR, OR, increment, decrement, decimal adjust after BCD arithmetic, complement, set carry and complement carry. Flags an operation does not define leave the block with the value they came in with, so the surrounding register file can load all four flag bits on every cycle. Register storage, shifts and memory traffic belong to the neighbouring blocks.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res_q`=0, `res_we_q`=0, `flags_q`=0 and `flag_mask_q`=0.
- R2: Codes 0 (add) and 1 (add with carry, which adds the incoming carry) give the 8-bit sum; the half-carry bit (bit 1 of the flag vectors) is the carry out of bit 3, the carry bit (bit 0) is the carry out of bit 7, the zero bit (bit 3) is set on a zero result, the subtract bit (bit 2) is cleared, and the result is written.
- R3: Codes 2 (subtract) and 3 (subtract with borrow, which also subtracts the incoming carry) give the 8-bit difference; half-carry is the borrow into bit 4, carry is the borrow out of bit 7, zero follows the result, subtract is set, and the result is written.
- R4: Code 7 (compare) produces the same difference and flags as code 2 but drives `res_we_q` low.
- R5: Codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result; AND sets half-carry, XOR and OR clear it; all three clear subtract and carry and set zero on a zero result.
- R6: Codes 8 (increment) and 9 (decrement) act on operand A alone, update zero and half-carry, clear (8) or set (9) subtract, and leave carry unmasked so it passes through unchanged.
- R7: Code 10 (decimal adjust) forms a correction with 0x06 when incoming half-carry is set or (subtract clear and the low nibble of A exceeds 9), and 0x60 when incoming carry is set or (subtract clear and A exceeds 0x99); the correction is subtracted from A when incoming subtract is set and added otherwise.
- R8: After code 10, carry equals the 0x60 condition, half-carry is cleared, zero follows the result and subtract keeps its incoming value.
- R9: Code 11 (complement) writes the bitwise inverse of A and sets subtract and half-carry; zero and carry pass through.
- R10: Codes 12 (set carry) and 13 (invert carry) set or invert carry, clear subtract and half-carry, leave zero unchanged and do not write the result.
- R11: Any flag whose mask bit is low leaves with its incoming value; codes 14 and 15 write nothing and mask every flag.
- R12: All outputs are registered: the values seen after a rising edge belong to the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 8 | Accumulator operand |
| op_b | input | 8 | Second operand |
| op_sel | input | 4 | Operation code |
| flags_in | input | 4 | Incoming flags {zero, subtract, half-carry, carry} |
| res_q | output | 8 | Registered result byte |
| res_we_q | output | 1 | Result write-back strobe |
| flags_q | output | 4 | Outgoing flags, same bit order as `flags_in` |
| flag_mask_q | output | 4 | High for each flag the operation defined |

## Verification
The bound checker watches, on every cycle, the properties that need no arithmetic beyond one cycle of history: the reset values, pass-through of masked flags, zero tracking the result whenever it is defined, the compare and carry operations never writing back, increment and decrement never touching carry, decimal adjust clearing half-carry and keeping subtract, and the 9-bit add relation. The exact half-carry and borrow values of the subtract paths, both directions of the decimal correction and the boundary operands (0x0F, 0xFF, 0x00, 0x9A) are shown only by the bench's directed and pseudo-random vectors compared against its behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int ALU_W  = 8;
  localparam int NIB_W  = ALU_W / 2;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;

  // flag vector bit positions (neighbouring register file decodes these)
  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_DAJ = 4'd10,
    OP_NOT = 4'd11,
    OP_STC = 4'd12,
    OP_CMC = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logic_sel_e;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         half,
  output logic         carry
);
  localparam int NIB = W / 2;

  logic [NIB:0] lo_ext;
  logic [W:0]   full_ext;
  logic [NIB:0] lo_cin;
  logic [W:0]   full_cin;

  assign lo_cin   = {{NIB{1'b0}}, cin};
  assign full_cin = {{W{1'b0}}, cin};

  always_comb begin
    if (sub) begin
      lo_ext   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - lo_cin;
      full_ext = {1'b0, a} - {1'b0, b} - full_cin;
    end else begin
      lo_ext   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + lo_cin;
      full_ext = {1'b0, a} + {1'b0, b} + full_cin;
    end
  end

  // top bit of each extended value is the carry (add) or borrow (sub)
  assign y     = full_ext[W-1:0];
  assign half  = lo_ext[NIB];
  assign carry = full_ext[W];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_XOR:  y = a ^ b;
      LG_OR:   y = a | b;
      default: y = a | b;
    endcase
  end
endmodule

// File: rtl/alu8_bcd_adj.sv
module alu8_bcd_adj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         n_in,
  input  logic         h_in,
  input  logic         c_in,
  output logic [W-1:0] y,
  output logic         c_out
);
  localparam int NIB = W / 2;
  localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
  localparam logic [NIB-1:0] DIGIT_FIX = NIB'(6);
  localparam logic [W-1:0]   BYTE_MAX  = {DIGIT_MAX, DIGIT_MAX};

  logic           fix_lo;
  logic           fix_hi;
  logic [W-1:0]   corr;

  assign fix_lo = h_in | (~n_in & (a[NIB-1:0] > DIGIT_MAX));
  assign fix_hi = c_in | (~n_in & (a > BYTE_MAX));
  assign corr   = {(fix_hi ? DIGIT_FIX : {NIB{1'b0}}),
                   (fix_lo ? DIGIT_FIX : {NIB{1'b0}})};
  assign y      = n_in ? (a - corr) : (a + corr);
  assign c_out  = fix_hi;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W  = ALU_W,
  parameter int FW = FLAG_W,
  parameter int OW = OP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [OW-1:0] op_sel,
  input  logic [FW-1:0] flags_in,
  output logic [W-1:0]  res_q,
  output logic          res_we_q,
  output logic [FW-1:0] flags_q,
  output logic [FW-1:0] flag_mask_q
);
  alu_op_e    op;
  flags_t     fin;
  assign op  = alu_op_e'(op_sel);
  assign fin = flags_t'(flags_in);

  // shared adder / subtractor
  logic         as_sub;
  logic         as_cin;
  logic         as_unary;
  logic [W-1:0] as_b;
  logic [W-1:0] as_y;
  logic         as_h;
  logic         as_c;

  assign as_unary = (op == OP_INC) || (op == OP_DEC);
  assign as_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP) || (op == OP_DEC);
  assign as_cin   = ((op == OP_ADC) || (op == OP_SBC)) ? fin.c : 1'b0;
  assign as_b     = as_unary ? W'(1) : op_b;

  alu8_addsub #(.W(W)) u_addsub (
    .a     (op_a),
    .b     (as_b),
    .cin   (as_cin),
    .sub   (as_sub),
    .y     (as_y),
    .half  (as_h),
    .carry (as_c)
  );

  logic_sel_e   lg_sel;
  logic [W-1:0] lg_y;

  always_comb begin
    unique case (op)
      OP_AND:  lg_sel = LG_AND;
      OP_XOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_OR;
    endcase
  end

  alu8_logic #(.W(W)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .sel (lg_sel),
    .y   (lg_y)
  );

  logic [W-1:0] dj_y;
  logic         dj_c;

  alu8_bcd_adj #(.W(W)) u_bcd (
    .a     (op_a),
    .n_in  (fin.n),
    .h_in  (fin.h),
    .c_in  (fin.c),
    .y     (dj_y),
    .c_out (dj_c)
  );

  // per-operation selection
  logic [W-1:0] nxt_res;
  logic         nxt_we;
  flags_t       nxt_val;
  flags_t       nxt_mask;
  logic         nxt_zero;

  assign nxt_zero = (nxt_res == '0);

  always_comb begin
    nxt_res  = op_a;
    nxt_we   = 1'b0;
    nxt_val  = '0;
    nxt_mask = '0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        nxt_res  = as_y;
        nxt_we   = 1'b1;
        nxt_val  = '{z: nxt_zero, n: 1'b0, h: as_h, c: as_c};
        nxt_mask = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        nxt_res  = as_y;
        nxt_we   = (op != OP_CMP);
        nxt_val  = '{z: nxt_zero, n: 1'b1, h: as_h, c: as_c};
        nxt_mask = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
      end
      OP_AND, OP_XOR, OP_OR: begin
        nxt_res  = lg_y;
        nxt_we   = 1'b1;
        nxt_val  = '{z: nxt_zero, n: 1'b0, h: (op == OP_AND), c: 1'b0};
        nxt_mask = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b1};
      end
      OP_INC, OP_DEC: begin
        nxt_res  = as_y;
        nxt_we   = 1'b1;
        nxt_val  = '{z: nxt_zero, n: (op == OP_DEC), h: as_h, c: 1'b0};
        nxt_mask = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
      end
      OP_DAJ: begin
        nxt_res  = dj_y;
        nxt_we   = 1'b1;
        nxt_val  = '{z: nxt_zero, n: 1'b0, h: 1'b0, c: dj_c};
        nxt_mask = '{z: 1'b1, n: 1'b0, h: 1'b1, c: 1'b1};
      end
      OP_NOT: begin
        nxt_res  = ~op_a;
        nxt_we   = 1'b1;
        nxt_val  = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b0};
        nxt_mask = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b0};
      end
      OP_STC, OP_CMC: begin
        nxt_val  = '{z: 1'b0, n: 1'b0, h: 1'b0, c: (op == OP_STC) | ~fin.c};
        nxt_mask = '{z: 1'b0, n: 1'b1, h: 1'b1, c: 1'b1};
      end
      default: begin
        nxt_res  = op_a;
        nxt_we   = 1'b0;
      end
    endcase
  end

  logic [FW-1:0] merged;
  assign merged = (nxt_val & nxt_mask) | (flags_in & ~nxt_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q       <= '0;
      res_we_q    <= 1'b0;
      flags_q     <= '0;
      flag_mask_q <= '0;
    end else begin
      res_q       <= nxt_res;
      res_we_q    <= nxt_we;
      flags_q     <= merged;
      flag_mask_q <= nxt_mask;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W  = ALU_W,
  parameter int FW = FLAG_W,
  parameter int OW = OP_W
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic [OW-1:0] op_sel,
  input logic [FW-1:0] flags_in,
  input logic [W-1:0]  res_q,
  input logic          res_we_q,
  input logic [FW-1:0] flags_q,
  input logic [FW-1:0] flag_mask_q
);
  // high once the outputs were loaded from inputs at the previous edge
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !res_we_q && flags_q == '0 && flag_mask_q == '0));

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == OP_ADD) |->
      ({flags_q[FC], res_q} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

  assert_zero_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    flag_mask_q[FZ] |-> (flags_q[FZ] == (res_q == '0)));

  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == OP_CMP) |-> (!res_we_q && flags_q[FN]));

  assert_incdec_keep_c_R6: assert property (@(posedge clk) disable iff (rst)
    (live && ($past(op_sel) == OP_INC || $past(op_sel) == OP_DEC)) |->
      (!flag_mask_q[FC] && flags_q[FC] == $past(flags_in[FC])));

  assert_daj_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (live && $past(op_sel) == OP_DAJ) |->
      (!flags_q[FH] && flags_q[FN] == $past(flags_in[FN])));

  assert_carry_ops_R10: assert property (@(posedge clk) disable iff (rst)
    (live && ($past(op_sel) == OP_STC || $past(op_sel) == OP_CMC)) |->
      (!res_we_q && !flags_q[FN] && !flags_q[FH]));

  assert_masked_pass_R11: assert property (@(posedge clk) disable iff (rst)
    live |-> (((flags_q ^ $past(flags_in)) & ~flag_mask_q) == '0));
endmodule

bind alu8_core alu8_core_chk #(.W(W), .FW(FW), .OW(OW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_a        (op_a),
  .op_b        (op_b),
  .op_sel      (op_sel),
  .flags_in    (flags_in),
  .res_q       (res_q),
  .res_we_q    (res_we_q),
  .flags_q     (flags_q),
  .flag_mask_q (flag_mask_q)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] op_a, op_b;
  logic [3:0] op_sel;
  logic [3:0] flags_in;
  logic [7:0] res_q;
  logic       res_we_q;
  logic [3:0] flags_q;
  logic [3:0] flag_mask_q;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  alu8_core dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flags_in(flags_in), .res_q(res_q), .res_we_q(res_we_q),
    .flags_q(flags_q), .flag_mask_q(flag_mask_q)
  );

  function automatic string req_of(input int op);
    case (op)
      0, 1:          return "R2";
      2, 3:          return "R3";
      7:             return "R4";
      4, 5, 6:       return "R5";
      8, 9:          return "R6";
      10:            return "R7/R8";
      11:            return "R9";
      12, 13:        return "R10";
      default:       return "R11";
    endcase
  endfunction

  // behavioural reference; flag order {Z,N,H,C}
  task automatic model(input int op, input int a, input int b, input int fi,
                       output int r, output int we, output int fo, output int m);
    int z, n, h, c, ci, s, cor, lo, hi;
    int fz, fn, fh, fc;
    fz = (fi >> 3) & 1; fn = (fi >> 2) & 1; fh = (fi >> 1) & 1; fc = fi & 1;
    r = a; we = 0; m = 0; z = 0; n = 0; h = 0; c = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? fc : 0;
        s = a + b + ci;
        r = s % 256; h = ((a % 16) + (b % 16) + ci) > 15; c = s > 255;
        n = 0; we = 1; m = 15;
      end
      2, 3, 7: begin
        ci = (op == 3) ? fc : 0;
        s = a - b - ci;
        r = (s + 512) % 256; h = ((a % 16) - (b % 16) - ci) < 0; c = s < 0;
        n = 1; we = (op != 7); m = 15;
      end
      4, 5, 6: begin
        r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
        h = (op == 4); n = 0; c = 0; we = 1; m = 15;
      end
      8, 9: begin
        r = (op == 8) ? (a + 1) % 256 : (a + 255) % 256;
        h = (op == 8) ? ((a % 16) == 15) : ((a % 16) == 0);
        n = (op == 9); we = 1; m = 14;
      end
      10: begin
        lo = fh || (!fn && (a % 16) > 9);
        hi = fc || (!fn && a > 153);
        cor = (lo ? 6 : 0) + (hi ? 96 : 0);
        r = fn ? (a - cor + 256) % 256 : (a + cor) % 256;
        c = hi; h = 0; we = 1; m = 11;
      end
      11: begin r = 255 - a; n = 1; h = 1; we = 1; m = 6; end
      12: begin c = 1; m = 7; end
      13: begin c = !fc; m = 7; end
      default: ;
    endcase
    z = (r == 0);
    fo = (((m >> 3) & 1) ? z : fz) * 8 + (((m >> 2) & 1) ? n : fn) * 4 +
         (((m >> 1) & 1) ? h : fh) * 2 + ((m & 1) ? c : fc);
  endtask

  // drive at negedge, register at posedge, compare at following negedge (R12)
  task automatic apply(input int op, input int a, input int b, input int fi);
    int er, ewe, ef, em;
    op_sel = 4'(op); op_a = 8'(a); op_b = 8'(b); flags_in = 4'(fi);
    model(op, a, b, fi, er, ewe, ef, em);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (res_q !== 8'(er) || res_we_q !== 1'(ewe) || flags_q !== 4'(ef) ||
        flag_mask_q !== 4'(em)) begin
      n_fail++;
      $display("FAIL %s/R12 op=%0d a=%02h b=%02h fi=%h: got res=%02h we=%b fl=%h m=%h exp res=%02h we=%0d fl=%h m=%h",
               req_of(op), op, a, b, fi, res_q, res_we_q, flags_q, flag_mask_q,
               er, ewe, ef, em);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_a = 8'hA5; op_b = 8'h5A; op_sel = 4'd0; flags_in = 4'hF;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    n_vec++;
    if (res_q !== 8'h00 || res_we_q !== 1'b0 || flags_q !== 4'h0 || flag_mask_q !== 4'h0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%02h we=%b fl=%h m=%h exp 00 0 0 0",
               res_q, res_we_q, flags_q, flag_mask_q);
    end
    rst = 1'b0;

    // R2 boundaries
    apply(0, 8'h0F, 8'h01, 0);
    apply(0, 8'hFF, 8'h01, 0);
    apply(1, 8'h7F, 8'h80, 1);
    // R3 borrows
    apply(2, 8'h10, 8'h01, 0);
    apply(2, 8'h00, 8'h01, 0);
    apply(3, 8'h05, 8'h04, 1);
    // R4 compare equal
    apply(7, 8'h3C, 8'h3C, 0);
    // R5 zero and H behaviour
    apply(4, 8'hF0, 8'h0F, 15);
    apply(5, 8'hAA, 8'hAA, 15);
    apply(6, 8'h00, 8'h00, 0);
    // R6 carry kept through overflow and underflow
    apply(8, 8'hFF, 8'h00, 1);
    apply(9, 8'h01, 8'h00, 0);
    apply(9, 8'h00, 8'h00, 0);
    // R7/R8 both directions
    apply(10, 8'h9A, 8'h00, 0);
    apply(10, 8'h45, 8'h00, 0);
    apply(10, 8'h0F, 8'h00, 4'b0110);
    apply(10, 8'h40, 8'h00, 4'b0101);
    // R9, R10
    apply(11, 8'h5A, 8'h00, 4'b1001);
    apply(12, 8'h12, 8'h00, 4'b1110);
    apply(13, 8'h12, 8'h00, 4'b0111);
    apply(13, 8'h12, 8'h00, 4'b0110);
    // R11 unused codes
    apply(14, 8'h77, 8'h11, 4'b1010);
    apply(15, 8'h00, 8'hFF, 4'b0101);

    // pseudo-random sweep over every code
    for (int i = 0; i < 4000; i++) begin
      int unsigned rv;
      rv = $urandom();
      apply(int'(rv % 16), int'((rv >> 4) % 256), int'((rv >> 12) % 256),
            int'((rv >> 20) % 16));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule